// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer with Locked Entries

This block translates 32-bit virtual addresses to physical addresses through a fully associative table of 16 entries. Each entry covers two adjacent virtual pages, one even and one odd, and points them at two independent physical frames. Each entry also has its own page size, from 4 KB up to 16 MB in steps of four. A lookup compares all entries at once and returns the physical address, a cache attribute and a hit flag in the same cycle as the address. Nothing is registered on the lookup path.

Software fills the table through one write port. The target is either an explicit index or the current value of a random victim counter. The counter never points at the low, locked entries, and software sets how many entries are locked. The page size is taken from a staging register at the moment of the write, so each entry keeps the size it was written with. A probe port searches by virtual page number and address-space identifier. It returns the index of the matching entry, or a miss flag.

Top module: `pair_tlb`

## Requirements
- R1: After an indexed write, a lookup whose virtual page, address-space identifier and valid bit match returns hit_o=1 in the same cycle. The physical address is the stored frame number followed by the untranslated offset bits of the virtual address.
- R2: The virtual address bit just above the page offset (bit 12 + 2*size) selects the physical frame. 0 selects the even frame and 1 selects the odd frame. Each frame has its own valid bit, and that bit gates the hit.
- R3: Size code s (0 = 4 KB, 1 = 16 KB, up to 6 = 16 MB) ignores the low 2*s bits of the 19-bit page-pair number in the compare. It passes the low 12+2*s virtual address bits through unchanged. Codes 7 and above are loaded into the staging register as 6.
- R4: An entry uses the staging size that was present when it was written. Later loads of the staging register do not change existing entries.
- R5: An entry matches only when its stored identifier equals the request identifier, or when its global bit is set.
- R6: With lk_user_i=1 and virtual address bit 31 set, lk_addr_err_o=1 and lk_hit_o=0. With lk_user_i=0 the upper half translates normally.
- R7: Attribute codes are 0 uncached, 1 write-back and 2 write-through without write-allocate. A write of code 3 is stored as 0.
- R8: The random index is 15 out of reset. It steps down by one every cycle until it equals the locked count, then returns to 15. A write of the locked count sets it to 15 on the next cycle.
- R9: A random write lands at the index shown on rand_idx_o in the cycle of the write. That index is never below the locked count, so locked entries survive random writes.
- R10: The probe result carries the lowest matching index in bits 3:0, with bit 31 clear. On no match, bit 31 is 1 and all other bits are 0. The probe ignores the valid bits.
- R11: multi_hit_o is 1 when more than one entry's tag matches either the lookup or the probe.
- R12: During reset all entries are invalid, the locked count is 0, the staging size is 0 and the random index is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_asid_i | input | 8 | Lookup address-space identifier |
| lk_user_i | input | 1 | Lookup issued in user mode |
| lk_pa_o | output | 32 | Translated physical address (0 on miss) |
| lk_attr_o | output | 2 | Cache attribute of the selected page |
| lk_hit_o | output | 1 | Lookup hit |
| lk_addr_err_o | output | 1 | User access to the upper half |
| pgsize_we_i | input | 1 | Load the staging page size |
| pgsize_i | input | 3 | Staging page size code |
| wr_en_i | input | 1 | Write an entry |
| wr_rand_i | input | 1 | Use the random index instead of wr_idx_i |
| wr_idx_i | input | 4 | Indexed write target |
| wr_vpn2_i | input | 19 | Page-pair number (virtual address bits 31:13) |
| wr_asid_i | input | 8 | Identifier for the entry |
| wr_g_i | input | 1 | Global bit |
| wr_pfn0_i | input | 20 | Even frame number |
| wr_attr0_i | input | 2 | Even page attribute |
| wr_v0_i | input | 1 | Even page valid |
| wr_pfn1_i | input | 20 | Odd frame number |
| wr_attr1_i | input | 2 | Odd page attribute |
| wr_v1_i | input | 1 | Odd page valid |
| wired_we_i | input | 1 | Load the locked count |
| wired_i | input | 4 | Number of locked low entries |
| rand_idx_o | output | 4 | Current random victim index |
| pr_vpn2_i | input | 19 | Probe page-pair number |
| pr_asid_i | input | 8 | Probe identifier |
| pr_result_o | output | 32 | Probe result: miss flag in bit 31, index in bits 3:0 |
| multi_hit_o | output | 1 | More than one tag match |

## Verification
The bench builds the block with its default parameters: 16 entries, 4-bit indices and the full range of seven page sizes. With these values the bench can reach the 16 MB size through the clamped code 7, with a 12-bit masked compare and bit 24 choosing between the two frames. It can also reach a locked count of 12, where the random counter cycles through only four values and its wrap can be seen within a few cycles. A locked count of 4 shields an entry written earlier while random writes land on entries above it.

// File: rtl/ptlb_pkg.sv
`timescale 1ns/1ps
package ptlb_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = VA_W;
  localparam int PG_SHIFT = 12;
  localparam int VPN2_W   = VA_W - PG_SHIFT - 1;
  localparam int PFN_W    = PA_W - PG_SHIFT;
  localparam int ASID_W   = 8;
  localparam int SZ_W     = 3;
  localparam int SZ_MAX   = 6;

  localparam logic [1:0] ATTR_UC = 2'd0;
  localparam logic [1:0] ATTR_WB = 2'd1;
  localparam logic [1:0] ATTR_WT = 2'd2;

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    logic [ASID_W-1:0] asid;
    logic              g;
    logic [SZ_W-1:0]   sz;
    logic [PFN_W-1:0]  pfn0;
    logic [1:0]        attr0;
    logic              v0;
    logic [PFN_W-1:0]  pfn1;
    logic [1:0]        attr1;
    logic              v1;
  } ent_t;

  function automatic logic [SZ_W-1:0] clamp_sz(logic [SZ_W-1:0] s);
    return (s > SZ_W'(SZ_MAX)) ? SZ_W'(SZ_MAX) : s;
  endfunction

  function automatic logic [1:0] fix_attr(logic [1:0] a);
    return (a == 2'd3) ? ATTR_UC : a;
  endfunction

  // page-pair number bits excluded from the compare
  function automatic logic [VPN2_W-1:0] vpn_mask(logic [SZ_W-1:0] s);
    logic [VPN2_W-1:0] m;
    m = '0;
    for (int i = 0; i < SZ_MAX; i++)
      if (SZ_W'(i) < s) m[2*i +: 2] = 2'b11;
    return m;
  endfunction

  function automatic logic [VA_W-1:0] off_mask(logic [SZ_W-1:0] s);
    return (VA_W'(1) << (PG_SHIFT + 2*int'(s))) - VA_W'(1);
  endfunction
endpackage

// File: rtl/ptlb_entry.sv
`timescale 1ns/1ps
module ptlb_entry
  import ptlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  ent_t              wdata_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN2_W-1:0] pr_vpn2_i,
  input  logic [ASID_W-1:0] pr_asid_i,
  output logic              lk_tag_o,
  output logic              lk_hit_o,
  output logic [PA_W-1:0]   lk_pa_o,
  output logic [1:0]        lk_attr_o,
  output logic              pr_tag_o
);
  ent_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (we_i) q <= wdata_i;
  end

  logic [VPN2_W-1:0] vm;
  logic [VA_W-1:0]   om;
  logic              odd;
  logic [PFN_W-1:0]  pfn_sel;

  always_comb begin
    vm  = vpn_mask(q.sz);
    om  = off_mask(q.sz);
    odd = lk_va_i[PG_SHIFT + 2*int'(q.sz)];
    lk_tag_o = (((q.vpn2 ^ lk_va_i[VA_W-1 -: VPN2_W]) & ~vm) == '0)
               && (q.g || (q.asid == lk_asid_i));
    pr_tag_o = (((q.vpn2 ^ pr_vpn2_i) & ~vm) == '0)
               && (q.g || (q.asid == pr_asid_i));
    pfn_sel   = odd ? q.pfn1 : q.pfn0;
    lk_attr_o = odd ? q.attr1 : q.attr0;
    lk_hit_o  = lk_tag_o && (odd ? q.v1 : q.v0);
    lk_pa_o   = ({pfn_sel, {PG_SHIFT{1'b0}}} & ~om) | (lk_va_i & om);
  end
endmodule

// File: rtl/ptlb_rand.sv
`timescale 1ns/1ps
module ptlb_rand #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wired_we_i,
  input  logic [IDX_W-1:0] wired_i,
  output logic [IDX_W-1:0] wired_o,
  output logic [IDX_W-1:0] rnd_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wired_o <= '0;
      rnd_o   <= LAST;
    end else if (wired_we_i) begin
      wired_o <= wired_i;
      rnd_o   <= LAST;
    end else begin
      rnd_o <= (rnd_o <= wired_o) ? LAST : rnd_o - 1'b1;
    end
  end
endmodule

// File: rtl/ptlb_enc.sv
`timescale 1ns/1ps
module ptlb_enc #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             multi_o
);
  logic [IDX_W:0] cnt;

  always_comb begin
    idx_o = '0;
    cnt   = '0;
    for (int i = N-1; i >= 0; i--)
      if (vec_i[i]) idx_o = IDX_W'(i);
    for (int i = 0; i < N; i++)
      cnt = cnt + (IDX_W+1)'(vec_i[i]);
    any_o   = |vec_i;
    multi_o = cnt > (IDX_W+1)'(1);
  end
endmodule

// File: rtl/pair_tlb.sv
`timescale 1ns/1ps
module pair_tlb
  import ptlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_user_i,
  output logic [PA_W-1:0]   lk_pa_o,
  output logic [1:0]        lk_attr_o,
  output logic              lk_hit_o,
  output logic              lk_addr_err_o,
  input  logic              pgsize_we_i,
  input  logic [SZ_W-1:0]   pgsize_i,
  input  logic              wr_en_i,
  input  logic              wr_rand_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN2_W-1:0] wr_vpn2_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_g_i,
  input  logic [PFN_W-1:0]  wr_pfn0_i,
  input  logic [1:0]        wr_attr0_i,
  input  logic              wr_v0_i,
  input  logic [PFN_W-1:0]  wr_pfn1_i,
  input  logic [1:0]        wr_attr1_i,
  input  logic              wr_v1_i,
  input  logic              wired_we_i,
  input  logic [IDX_W-1:0]  wired_i,
  output logic [IDX_W-1:0]  rand_idx_o,
  input  logic [VPN2_W-1:0] pr_vpn2_i,
  input  logic [ASID_W-1:0] pr_asid_i,
  output logic [31:0]       pr_result_o,
  output logic              multi_hit_o
);
  logic [SZ_W-1:0]  pgsize_q;
  logic [IDX_W-1:0] wired_q;
  logic [IDX_W-1:0] wr_tgt;
  ent_t             wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pgsize_q <= '0;
    else if (pgsize_we_i) pgsize_q <= clamp_sz(pgsize_i);
  end

  ptlb_rand #(.N_ENTRIES(N_ENTRIES)) u_rand (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wired_we_i(wired_we_i), .wired_i(wired_i),
    .wired_o(wired_q), .rnd_o(rand_idx_o)
  );

  always_comb begin
    wr_tgt      = wr_rand_i ? rand_idx_o : wr_idx_i;
    wdata.vpn2  = wr_vpn2_i;
    wdata.asid  = wr_asid_i;
    wdata.g     = wr_g_i;
    wdata.sz    = pgsize_q;
    wdata.pfn0  = wr_pfn0_i;
    wdata.attr0 = fix_attr(wr_attr0_i);
    wdata.v0    = wr_v0_i;
    wdata.pfn1  = wr_pfn1_i;
    wdata.attr1 = fix_attr(wr_attr1_i);
    wdata.v1    = wr_v1_i;
  end

  logic [N_ENTRIES-1:0] lk_tag_v, lk_hit_v, pr_tag_v;
  logic [PA_W-1:0]      pa_a   [N_ENTRIES];
  logic [1:0]           attr_a [N_ENTRIES];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    ptlb_entry u_ent (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .we_i(wr_en_i && (wr_tgt == IDX_W'(i))),
      .wdata_i(wdata),
      .lk_va_i(lk_va_i), .lk_asid_i(lk_asid_i),
      .pr_vpn2_i(pr_vpn2_i), .pr_asid_i(pr_asid_i),
      .lk_tag_o(lk_tag_v[i]), .lk_hit_o(lk_hit_v[i]),
      .lk_pa_o(pa_a[i]), .lk_attr_o(attr_a[i]),
      .pr_tag_o(pr_tag_v[i])
    );
  end

  logic [IDX_W-1:0] lk_idx, pr_idx, tag_idx_unused;
  logic             lk_any, pr_any, lk_multi, pr_multi, hit_multi_unused, tag_any_unused;

  ptlb_enc #(.N(N_ENTRIES)) u_enc_hit (
    .vec_i(lk_hit_v), .idx_o(lk_idx), .any_o(lk_any), .multi_o(hit_multi_unused)
  );
  ptlb_enc #(.N(N_ENTRIES)) u_enc_tag (
    .vec_i(lk_tag_v), .idx_o(tag_idx_unused), .any_o(tag_any_unused), .multi_o(lk_multi)
  );
  ptlb_enc #(.N(N_ENTRIES)) u_enc_pr (
    .vec_i(pr_tag_v), .idx_o(pr_idx), .any_o(pr_any), .multi_o(pr_multi)
  );

  always_comb begin
    lk_addr_err_o = lk_user_i && lk_va_i[VA_W-1];
    lk_hit_o      = lk_any && !lk_addr_err_o;
    lk_pa_o       = lk_hit_o ? pa_a[lk_idx]   : '0;
    lk_attr_o     = lk_hit_o ? attr_a[lk_idx] : ATTR_UC;
    pr_result_o   = pr_any ? {{(32-IDX_W){1'b0}}, pr_idx} : {1'b1, 31'b0};
    multi_hit_o   = lk_multi || pr_multi;
  end
endmodule

// File: rtl/pair_tlb_chk.sv
`timescale 1ns/1ps
module pair_tlb_chk #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wired_we_i,
  input logic [IDX_W-1:0] wired_q,
  input logic [IDX_W-1:0] rnd_q,
  input logic             user_i,
  input logic             va_top_i,
  input logic [11:0]      va_off_i,
  input logic [11:0]      pa_off_i,
  input logic             hit_i,
  input logic             addr_err_i,
  input logic [1:0]       attr_i,
  input logic [31:0]      pr_result_i
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES-1);

  assert_offset_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> pa_off_i == va_off_i);

  assert_user_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_i && va_top_i) |-> (addr_err_i && !hit_i));

  assert_attr_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> attr_i != 2'd3);

  assert_rand_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wired_we_i && rnd_q > wired_q) |=> rnd_q == IDX_W'($past(rnd_q) - 1'b1));

  assert_rand_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wired_we_i && rnd_q <= wired_q) |=> rnd_q == LAST);

  assert_wired_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wired_we_i |=> rnd_q == LAST);

  assert_rand_unlocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rnd_q >= wired_q) || (rnd_q == LAST));

  assert_probe_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_result_i[31] |-> pr_result_i[30:0] == 31'b0);
endmodule

bind pair_tlb pair_tlb_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wired_we_i(wired_we_i), .wired_q(wired_q), .rnd_q(rand_idx_o),
  .user_i(lk_user_i), .va_top_i(lk_va_i[31]), .va_off_i(lk_va_i[11:0]),
  .pa_off_i(lk_pa_o[11:0]), .hit_i(lk_hit_o), .addr_err_i(lk_addr_err_o),
  .attr_i(lk_attr_o), .pr_result_i(pr_result_o)
);

// File: tb/tb_pair_tlb.sv
`timescale 1ns/1ps
module tb_pair_tlb;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [31:0] lk_va_i = 0;
  logic [7:0]  lk_asid_i = 0;
  logic        lk_user_i = 0;
  logic [31:0] lk_pa_o;
  logic [1:0]  lk_attr_o;
  logic        lk_hit_o, lk_addr_err_o;
  logic        pgsize_we_i = 0;
  logic [2:0]  pgsize_i = 0;
  logic        wr_en_i = 0, wr_rand_i = 0;
  logic [3:0]  wr_idx_i = 0;
  logic [18:0] wr_vpn2_i = 0;
  logic [7:0]  wr_asid_i = 0;
  logic        wr_g_i = 0;
  logic [19:0] wr_pfn0_i = 0, wr_pfn1_i = 0;
  logic [1:0]  wr_attr0_i = 0, wr_attr1_i = 0;
  logic        wr_v0_i = 0, wr_v1_i = 0;
  logic        wired_we_i = 0;
  logic [3:0]  wired_i = 0;
  logic [3:0]  rand_idx_o;
  logic [18:0] pr_vpn2_i = 19'h7FFFF;
  logic [7:0]  pr_asid_i = 8'hFF;
  logic [31:0] pr_result_o;
  logic        multi_hit_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pair_tlb dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_size(logic [2:0] c);
    @(negedge clk_i); pgsize_we_i = 1; pgsize_i = c;
    @(negedge clk_i); pgsize_we_i = 0;
  endtask

  task automatic wr(logic [3:0] idx, logic [18:0] vpn2, logic [7:0] asid, logic g,
                    logic [19:0] p0, logic [1:0] a0, logic v0,
                    logic [19:0] p1, logic [1:0] a1, logic v1);
    @(negedge clk_i);
    wr_en_i = 1; wr_rand_i = 0; wr_idx_i = idx; wr_vpn2_i = vpn2; wr_asid_i = asid;
    wr_g_i = g; wr_pfn0_i = p0; wr_attr0_i = a0; wr_v0_i = v0;
    wr_pfn1_i = p1; wr_attr1_i = a1; wr_v1_i = v1;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic look(string req, logic [31:0] va, logic [7:0] asid, logic user,
                      logic hit, logic [31:0] pa, logic [1:0] attr);
    @(negedge clk_i); lk_va_i = va; lk_asid_i = asid; lk_user_i = user;
    #1;
    check(req, {31'b0, lk_hit_o}, {31'b0, hit});
    check(req, lk_pa_o, hit ? pa : 32'h0);
    if (hit) check(req, {30'b0, lk_attr_o}, {30'b0, attr});
  endtask

  task automatic probe(string req, logic [18:0] vpn2, logic [7:0] asid, logic [31:0] exp);
    @(negedge clk_i); pr_vpn2_i = vpn2; pr_asid_i = asid;
    #1 check(req, pr_result_o, exp);
    pr_vpn2_i = 19'h7FFFF; pr_asid_i = 8'hFF;
  endtask

  task automatic set_wired(logic [3:0] n);
    @(negedge clk_i); wired_we_i = 1; wired_i = n;
    @(negedge clk_i); wired_we_i = 0;
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk_i);
    check("R12 rand", {28'b0, rand_idx_o}, 32'd15);
    lk_va_i = 32'h0000_0123; lk_asid_i = 8'd0; #1;
    check("R12 lookup", {31'b0, lk_hit_o}, 32'd0);
    check("R12 probe", pr_result_o, 32'h8000_0000);
    @(negedge clk_i); rst_ni = 1;
    lk_asid_i = 8'd5;
  endtask

  task automatic t_basic;
    set_size(3'd0);
    wr(4'd3, 19'h10, 8'd5, 0, 20'h12345, 2'd1, 1, 20'h54321, 2'd2, 1);
    wr(4'd4, 19'h20, 8'd5, 0, 20'h11111, 2'd1, 1, 20'h0, 2'd0, 0);
    look("R1 even", 32'h0002_0ABC, 8'd5, 0, 1, 32'h1234_5ABC, 2'd1);
    look("R2 odd", 32'h0002_1ABC, 8'd5, 0, 1, 32'h5432_1ABC, 2'd2);
    look("R2 even valid", 32'h0004_0010, 8'd5, 0, 1, 32'h1111_1010, 2'd1);
    look("R2 odd invalid", 32'h0004_1000, 8'd5, 0, 0, 32'h0, 2'd0);
  endtask

  task automatic t_sizes;
    set_size(3'd1);
    wr(4'd5, 19'h100, 8'd5, 0, 20'h20000, 2'd1, 1, 20'h30000, 2'd1, 1);
    set_size(3'd7);
    wr(4'd6, 19'h40000, 8'd5, 0, 20'h05000, 2'd1, 1, 20'h07000, 2'd2, 1);
    set_size(3'd0);
    look("R3 16k even", 32'h0020_3ABC, 8'd5, 0, 1, 32'h2000_3ABC, 2'd1);
    look("R4 16k kept odd", 32'h0020_4123, 8'd5, 0, 1, 32'h3000_0123, 2'd1);
    look("R3 clamp 16M even", 32'h80AB_CDEF, 8'd5, 0, 1, 32'h05AB_CDEF, 2'd1);
    look("R3 clamp 16M odd", 32'h8100_0010, 8'd5, 0, 1, 32'h0700_0010, 2'd2);
    look("R3 16M outside", 32'h8200_0000, 8'd5, 0, 0, 32'h0, 2'd0);
  endtask

  task automatic t_user;
    look("R6 user upper", 32'h80AB_CDEF, 8'd5, 1, 0, 32'h0, 2'd0);
    #0 check("R6 err", {31'b0, lk_addr_err_o}, 32'd1);
    look("R6 user lower", 32'h0002_0ABC, 8'd5, 1, 1, 32'h1234_5ABC, 2'd1);
    #0 check("R6 no err", {31'b0, lk_addr_err_o}, 32'd0);
  endtask

  task automatic t_asid_attr;
    wr(4'd7, 19'h300, 8'd9, 1, 20'h0AAAA, 2'd0, 1, 20'h0, 2'd0, 0);
    wr(4'd8, 19'h400, 8'd5, 0, 20'h0BBBB, 2'd3, 1, 20'h0, 2'd0, 0);
    look("R5 asid mismatch", 32'h0002_0ABC, 8'd6, 0, 0, 32'h0, 2'd0);
    look("R5 global", 32'h0060_0456, 8'd1, 0, 1, 32'h0AAA_A456, 2'd0);
    look("R7 attr3 stored uc", 32'h0080_0010, 8'd5, 0, 1, 32'h0BBB_B010, 2'd0);
  endtask

  task automatic t_probe_multi;
    probe("R10 hit", 19'h10, 8'd5, 32'd3);
    probe("R10 ignores valid", 19'h20, 8'd5, 32'd4);
    probe("R10 global", 19'h300, 8'd3, 32'd7);
    probe("R10 miss", 19'h999, 8'd5, 32'h8000_0000);
    wr(4'd9, 19'h10, 8'd5, 0, 20'h1, 2'd1, 1, 20'h2, 2'd1, 1);
    @(negedge clk_i); lk_va_i = 32'h0002_0ABC; lk_asid_i = 8'd5; lk_user_i = 0;
    #1 check("R11 multi set", {31'b0, multi_hit_o}, 32'd1);
    wr(4'd9, 19'h700, 8'd5, 0, 20'h1, 2'd1, 1, 20'h2, 2'd1, 1);
    #1 check("R11 multi clear", {31'b0, multi_hit_o}, 32'd0);
  endtask

  task automatic t_random;
    logic [3:0] seen;
    set_wired(4'd12);
    check("R8 reload", {28'b0, rand_idx_o}, 32'd15);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      check("R8 sequence", {28'b0, rand_idx_o}, (k < 3) ? 32'(14 - k) : 32'(15 - (k - 3)));
    end
    set_wired(4'd4);
    for (int k = 0; k < 5; k++) begin
      repeat (k + 2) @(negedge clk_i);
      seen = rand_idx_o;
      check("R9 not locked", {31'b0, seen >= 4'd4}, 32'd1);
      wr_en_i = 1; wr_rand_i = 1; wr_vpn2_i = 19'h1000 + 19'(k); wr_asid_i = 8'd5;
      wr_g_i = 0; wr_pfn0_i = 20'h3; wr_attr0_i = 2'd1; wr_v0_i = 1; wr_v1_i = 0;
      @(negedge clk_i); wr_en_i = 0; wr_rand_i = 0;
      probe("R9 landed", 19'h1000 + 19'(k), 8'd5, {28'b0, seen});
    end
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      check("R9 range", {31'b0, rand_idx_o >= 4'd4}, 32'd1);
    end
    look("R9 locked survives", 32'h0002_0ABC, 8'd5, 0, 1, 32'h1234_5ABC, 2'd1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_sizes();
    t_user();
    t_asid_attr();
    t_probe_multi();
    t_random();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule